// File: doc/BRIEF.md
# Multithreaded Branch Direction Predictor

This block predicts taken or not taken for conditional branches in a core that runs four hardware threads at once. A table of 2-bit saturating counters supplies the prediction. A lookup carries a thread number, a branch address and the branch target, and is answered combinationally in the same cycle. A resolved branch comes back later on the update port with its thread number, address and actual outcome. The update trains one counter and, in the history modes, shifts that outcome into a global history register.

A static mode input picks how the four threads share the state. The options are a history-free bimodal table, four history-based sharing arrangements, and two stateless static rules. The mode is a strap. It may only change while reset is asserted, so table contents from one arrangement are never reused under another.

Top module: `smt_dir_pred`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken) and every history register holds zero, so every table-based mode predicts not taken until it is trained.
- R2: In table-based modes the prediction is taken exactly when the addressed counter is 2 or 3.
- R3: A valid update adds 1 to the addressed counter when the outcome is taken and subtracts 1 when it is not. The counter stays at 3 on a taken update and at 0 on a not-taken update.
- R4: Mode 0 (bimodal) indexes the 1024-entry table with PC[11:2] and uses no history.
- R5: Mode 1 (fully shared) indexes with PC[11:2] XOR a single history register that the updates of all threads feed.
- R6: Mode 2 (fully split) forms PC[11:2] XOR the history of the requesting thread, then replaces index bits [9:8] with the thread number, so each thread owns a 256-entry slice.
- R7: Mode 3 forms PC[11:2] XOR the single shared history, then replaces index bits [9:8] with the thread number.
- R8: Mode 4 indexes the whole table with PC[11:2] XOR the history register private to the requesting thread.
- R9: In modes 1 to 4 each valid update shifts the selected history left by one and inserts the outcome (1 = taken) at bit 0. The selected history is the thread's own in modes 2 and 4 and the shared one in modes 1 and 3. In mode 0 and the static modes the histories never change.
- R10: Modes 5 and 7 always predict taken, and updates have no effect on the prediction.
- R11: Mode 6 predicts taken when the target is below the branch address, compared as unsigned numbers, and not taken otherwise, including an equal target. Updates have no effect.
- R12: When a lookup and an update address the same counter in the same cycle, the lookup returns the value from before the update.
- R13: With the update valid low, neither the counters nor the histories change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Sharing/static mode select; change only during reset |
| lk_tid_i | input | 2 | Lookup thread number |
| lk_pc_i | input | 32 | Lookup branch address |
| lk_target_i | input | 32 | Lookup branch target (used by mode 6) |
| lk_taken_o | output | 1 | Predicted direction, 1 = taken |
| up_valid_i | input | 1 | Update strobe |
| up_tid_i | input | 2 | Update thread number |
| up_pc_i | input | 32 | Update branch address |
| up_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions assume that the mode input holds steady whenever reset is released. They also assume that the history-shift check is valid only for the history register chosen by the current mode. The stimulus respects this by setting the mode only while reset is held, then running a phase of fixed-seed random lookups and updates over a small address pool so that entries alias often. Directed sequences then drive counters into both saturation ends, present a lookup and an update to the same entry in one cycle, and hold the update strobe low while the update fields toggle.

// File: rtl/smt_bp_pkg.sv
package smt_bp_pkg;
  typedef enum logic [2:0] {
    BP_BIMODAL     = 3'd0,
    BP_SHARED      = 3'd1,
    BP_SPLIT       = 3'd2,
    BP_HIST_SLICED = 3'd3,
    BP_PRIV_HIST   = 3'd4,
    BP_STATIC_T    = 3'd5,
    BP_STATIC_DIR  = 3'd6,
    BP_STATIC_T2   = 3'd7
  } bp_mode_e;

  function automatic logic bp_uses_hist(bp_mode_e m);
    return (m == BP_SHARED) || (m == BP_SPLIT) || (m == BP_HIST_SLICED) || (m == BP_PRIV_HIST);
  endfunction

  function automatic logic bp_priv_hist(bp_mode_e m);
    return (m == BP_SPLIT) || (m == BP_PRIV_HIST);
  endfunction

  function automatic logic bp_sliced(bp_mode_e m);
    return (m == BP_SPLIT) || (m == BP_HIST_SLICED);
  endfunction

  function automatic logic bp_is_static(bp_mode_e m);
    return (m == BP_STATIC_T) || (m == BP_STATIC_DIR) || (m == BP_STATIC_T2);
  endfunction
endpackage

// File: rtl/bp_index.sv
module bp_index
  import smt_bp_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int TID_W = 2,
  parameter int PC_W  = 32,
  localparam int NT   = 1 << TID_W
) (
  input  bp_mode_e                    mode_i,
  input  logic [TID_W-1:0]            tid_i,
  input  logic [PC_W-1:0]             pc_i,
  input  logic [NT-1:0][IDX_W-1:0]    hist_all_i,
  output logic [IDX_W-1:0]            idx_o
);
  logic [IDX_W-1:0] hist_sel, hist_use, raw;

  always_comb begin
    hist_sel = bp_priv_hist(mode_i) ? hist_all_i[tid_i] : hist_all_i[0];
    hist_use = bp_uses_hist(mode_i) ? hist_sel : '0;
    raw      = pc_i[IDX_W+1:2] ^ hist_use;
    if (bp_sliced(mode_i)) idx_o = {tid_i, raw[IDX_W-TID_W-1:0]};
    else                   idx_o = raw;
  end
endmodule

// File: rtl/bp_hist_bank.sv
module bp_hist_bank
  import smt_bp_pkg::*;
#(
  parameter int HIST_W = 10,
  parameter int TID_W  = 2,
  localparam int NT    = 1 << TID_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  bp_mode_e                    mode_i,
  input  logic                        upd_i,
  input  logic [TID_W-1:0]            tid_i,
  input  logic                        taken_i,
  output logic [NT-1:0][HIST_W-1:0]   hist_o
);
  logic [TID_W-1:0] sel;
  logic             shift_en;

  assign sel      = bp_priv_hist(mode_i) ? tid_i : '0;
  assign shift_en = upd_i && bp_uses_hist(mode_i);

  for (genvar t = 0; t < NT; t++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  hist_o[t] <= '0;
      else if (shift_en && (sel == TID_W'(t)))      hist_o[t] <= {hist_o[t][HIST_W-2:0], taken_i};
    end
  end
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int IDX_W  = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [1:0]       rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  logic [1:0] ctr_q [DEPTH];
  logic [1:0] cur, nxt;

  assign rd_ctr_o = ctr_q[rd_idx_i];
  assign cur      = ctr_q[wr_idx_i];

  always_comb begin
    if (wr_taken_i) nxt = (cur == 2'd3) ? cur : cur + 2'd1;
    else            nxt = (cur == 2'd0) ? cur : cur - 2'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= 2'd1;
    end else if (wr_en_i) begin
      ctr_q[wr_idx_i] <= nxt;
    end
  end
endmodule

// File: rtl/smt_dir_pred.sv
module smt_dir_pred
  import smt_bp_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int TID_W = 2,
  parameter int PC_W  = 32,
  localparam int NT   = 1 << TID_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic [TID_W-1:0] lk_tid_i,
  input  logic [PC_W-1:0]  lk_pc_i,
  input  logic [PC_W-1:0]  lk_target_i,
  output logic             lk_taken_o,
  input  logic             up_valid_i,
  input  logic [TID_W-1:0] up_tid_i,
  input  logic [PC_W-1:0]  up_pc_i,
  input  logic             up_taken_i
);
  bp_mode_e                  mode;
  logic [NT-1:0][IDX_W-1:0]  hist_all;
  logic [IDX_W-1:0]          lk_idx, up_idx;
  logic [1:0]                lk_ctr;
  logic                      tbl_wr;

  assign mode   = bp_mode_e'(mode_i);
  assign tbl_wr = up_valid_i && !bp_is_static(mode);

  bp_index #(.IDX_W(IDX_W), .TID_W(TID_W), .PC_W(PC_W)) u_lk_idx (
    .mode_i(mode), .tid_i(lk_tid_i), .pc_i(lk_pc_i), .hist_all_i(hist_all), .idx_o(lk_idx)
  );

  bp_index #(.IDX_W(IDX_W), .TID_W(TID_W), .PC_W(PC_W)) u_up_idx (
    .mode_i(mode), .tid_i(up_tid_i), .pc_i(up_pc_i), .hist_all_i(hist_all), .idx_o(up_idx)
  );

  bp_hist_bank #(.HIST_W(IDX_W), .TID_W(TID_W)) u_hist (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .upd_i(up_valid_i),
    .tid_i(up_tid_i), .taken_i(up_taken_i), .hist_o(hist_all)
  );

  bp_ctr_table #(.IDX_W(IDX_W)) u_tbl (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_idx_i(lk_idx), .rd_ctr_o(lk_ctr),
    .wr_en_i(tbl_wr), .wr_idx_i(up_idx), .wr_taken_i(up_taken_i)
  );

  always_comb begin
    unique case (mode)
      BP_STATIC_T, BP_STATIC_T2: lk_taken_o = 1'b1;
      BP_STATIC_DIR:             lk_taken_o = (lk_target_i < lk_pc_i);
      default:                   lk_taken_o = lk_ctr[1];
    endcase
  end
endmodule

// File: rtl/smt_dir_pred_checks.sv
module smt_dir_pred_checks
  import smt_bp_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int TID_W = 2,
  parameter int PC_W  = 32,
  localparam int NT   = 1 << TID_W
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [2:0]                mode_i,
  input logic [PC_W-1:0]           lk_pc_i,
  input logic [PC_W-1:0]           lk_target_i,
  input logic                      lk_taken_o,
  input logic                      up_valid_i,
  input logic [TID_W-1:0]          up_tid_i,
  input logic                      up_taken_i,
  input logic [NT-1:0][IDX_W-1:0]  hist_all
);
  bp_mode_e         m;
  logic [TID_W-1:0] sel, sel_q;
  logic [IDX_W-1:0] exp_h, exp_q;
  logic             arm_q;

  assign m     = bp_mode_e'(mode_i);
  assign sel   = bp_priv_hist(m) ? up_tid_i : '0;
  assign exp_h = {hist_all[sel][IDX_W-2:0], up_taken_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      sel_q <= '0;
      exp_q <= '0;
    end else begin
      arm_q <= up_valid_i && bp_uses_hist(m);
      sel_q <= sel;
      exp_q <= exp_h;
    end
  end

  // mode is a strap: steady out of reset (all requirements rely on it)
  assert_mode_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(mode_i));

  assert_static_taken_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m == BP_STATIC_T || m == BP_STATIC_T2) |-> lk_taken_o);

  assert_btfn_dir_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m == BP_STATIC_DIR) |-> (lk_taken_o == (lk_target_i < lk_pc_i)));

  assert_hist_shift_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q |-> (hist_all[sel_q] == exp_q));

  assert_hist_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_valid_i |=> $stable(hist_all));

  assert_hist_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bp_uses_hist(m) |=> $stable(hist_all));
endmodule

bind smt_dir_pred smt_dir_pred_checks #(.IDX_W(IDX_W), .TID_W(TID_W), .PC_W(PC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .lk_pc_i(lk_pc_i),
  .lk_target_i(lk_target_i), .lk_taken_o(lk_taken_o), .up_valid_i(up_valid_i),
  .up_tid_i(up_tid_i), .up_taken_i(up_taken_i), .hist_all(hist_all)
);

// File: tb/smt_dir_pred_tb.sv
module smt_dir_pred_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic [1:0]  lk_tid_i = '0;
  logic [31:0] lk_pc_i = '0;
  logic [31:0] lk_target_i = '0;
  logic        lk_taken_o;
  logic        up_valid_i = 1'b0;
  logic [1:0]  up_tid_i = '0;
  logic [31:0] up_pc_i = '0;
  logic        up_taken_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  int unsigned ref_ctr [1024];
  logic [9:0]  ref_hist [4];

  always #5ns clk_i = ~clk_i;

  smt_dir_pred u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .lk_tid_i(lk_tid_i),
    .lk_pc_i(lk_pc_i), .lk_target_i(lk_target_i), .lk_taken_o(lk_taken_o),
    .up_valid_i(up_valid_i), .up_tid_i(up_tid_i), .up_pc_i(up_pc_i), .up_taken_i(up_taken_i)
  );

  function automatic int unsigned idx_of(int m, logic [1:0] t, logic [31:0] pc);
    logic [9:0] h, raw;
    h = '0;
    if (m >= 1 && m <= 4) h = (m == 2 || m == 4) ? ref_hist[t] : ref_hist[0];
    raw = pc[11:2] ^ h;
    if (m == 2 || m == 3) raw[9:8] = t;
    return int'(raw);
  endfunction

  function automatic logic exp_pred(int m);
    if (m == 5 || m == 7) return 1'b1;
    if (m == 6) return lk_target_i < lk_pc_i;
    return ref_ctr[idx_of(m, lk_tid_i, lk_pc_i)] >= 2;
  endfunction

  function automatic string tag_of(int m);
    case (m)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      6: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(logic got, logic exp, string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0b exp=%0b (mode %0d pc %h tid %0d)", tag, got, exp, mode_i, lk_pc_i, lk_tid_i);
    end
  endtask

  task automatic model_update();
    int m;
    int unsigned i;
    logic [1:0] s;
    m = int'(mode_i);
    if (up_valid_i && m <= 4) begin
      i = idx_of(m, up_tid_i, up_pc_i);
      if (up_taken_i) begin if (ref_ctr[i] < 3) ref_ctr[i]++; end
      else            begin if (ref_ctr[i] > 0) ref_ctr[i]--; end
      if (m >= 1) begin
        s = (m == 2 || m == 4) ? up_tid_i : 2'd0;
        ref_hist[s] = {ref_hist[s][8:0], up_taken_i};
      end
    end
  endtask

  // called just after a negedge with inputs already driven
  task automatic step(string tag);
    #1;
    chk(lk_taken_o, exp_pred(int'(mode_i)), tag);
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
  endtask

  function automatic logic [31:0] pool_pc();
    return 32'h0000_4000 + 32'($urandom_range(0, 23)) * 4;
  endfunction

  task automatic do_reset(int m);
    @(negedge clk_i);
    rst_ni = 1'b0;
    up_valid_i = 1'b0;
    mode_i = 3'(m);
    @(negedge clk_i);
    @(negedge clk_i);
    for (int i = 0; i < 1024; i++) ref_ctr[i] = 1;
    for (int t = 0; t < 4; t++) ref_hist[t] = '0;
    rst_ni = 1'b1;
  endtask

  task automatic rand_phase(int m, int n);
    for (int k = 0; k < n; k++) begin
      lk_tid_i    = 2'($urandom_range(0, 3));
      lk_pc_i     = pool_pc();
      lk_target_i = ($urandom_range(0, 1) == 1) ? lk_pc_i - 32'd64 : lk_pc_i + 32'd64;
      up_valid_i  = ($urandom_range(0, 3) != 0);
      up_tid_i    = 2'($urandom_range(0, 3));
      up_pc_i     = ($urandom_range(0, 2) == 0) ? lk_pc_i : pool_pc();
      up_taken_i  = ($urandom_range(0, 2) != 0);
      step(tag_of(m));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int m = 0; m < 8; m++) begin
      do_reset(m);
      // R1: fresh state predicts not taken in table modes
      for (int k = 0; k < 6; k++) begin
        lk_tid_i = 2'(k % 4);
        lk_pc_i = pool_pc();
        lk_target_i = lk_pc_i + 32'd8;
        #1;
        chk(lk_taken_o, (m == 5 || m == 7), (m <= 4) ? "R1" : tag_of(m));
        @(negedge clk_i);
      end
      rand_phase(m, 400);
    end

    // R2/R3: saturation both ends in bimodal mode
    do_reset(0);
    lk_tid_i = 2'd0; lk_pc_i = 32'h0000_8010; up_pc_i = lk_pc_i;
    up_valid_i = 1'b1; up_taken_i = 1'b1;
    for (int k = 0; k < 5; k++) step("R3");
    up_valid_i = 1'b0; #1; chk(lk_taken_o, 1'b1, "R3");
    up_valid_i = 1'b1; up_taken_i = 1'b0;
    step("R2"); step("R2");
    up_valid_i = 1'b0; #1; chk(lk_taken_o, 1'b0, "R2");
    up_valid_i = 1'b1;
    for (int k = 0; k < 4; k++) step("R3");
    up_taken_i = 1'b1; step("R3");
    up_valid_i = 1'b0; #1; chk(lk_taken_o, 1'b0, "R3");

    // R12: same-entry lookup and update in one cycle reads the old value
    do_reset(0);
    lk_pc_i = 32'h0000_9000; up_pc_i = lk_pc_i; up_valid_i = 1'b1; up_taken_i = 1'b1;
    #1; chk(lk_taken_o, 1'b0, "R12");
    @(negedge clk_i);
    up_taken_i = 1'b0;
    #1; chk(lk_taken_o, 1'b1, "R12");
    @(negedge clk_i);
    up_valid_i = 1'b0;
    #1; chk(lk_taken_o, 1'b0, "R12");
    @(negedge clk_i);

    // R13: strobe low, update fields toggling, state unchanged
    do_reset(1);
    lk_pc_i = 32'h0000_4004; lk_tid_i = 2'd1;
    for (int k = 0; k < 8; k++) begin
      up_valid_i = 1'b0; up_taken_i = 1'b1; up_pc_i = lk_pc_i; up_tid_i = 2'(k);
      step("R13");
    end
    #1; chk(lk_taken_o, 1'b0, "R13");

    // R9: private history in mode 2 shifts only for its own thread
    do_reset(2);
    up_valid_i = 1'b1; up_tid_i = 2'd2; up_taken_i = 1'b1; up_pc_i = 32'h0000_4000;
    lk_tid_i = 2'd2; lk_pc_i = 32'h0000_4000;
    for (int k = 0; k < 6; k++) step("R9");
    up_valid_i = 1'b0;
    for (int t = 0; t < 4; t++) begin
      lk_tid_i = 2'(t);
      step("R9");
    end
    rand_phase(2, 100);

    // R11: equal target is not taken
    do_reset(6);
    lk_pc_i = 32'h0000_5000; lk_target_i = lk_pc_i;
    #1; chk(lk_taken_o, 1'b0, "R11");
    lk_target_i = lk_pc_i - 32'd4;
    #1; chk(lk_taken_o, 1'b1, "R11");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1ms;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule